// File: doc/BRIEF.md
# Power-of-Two Requantizer with Rectifier

This stage sits after a multiply-accumulate array and turns each signed 24-bit accumulated sum into a signed 8-bit activation for the next layer. The scale between the two formats is a power of two, so the stage divides by selecting bits rather than by using a divider. No bias is added. A sum that does not fit in eight bits is clamped to the nearest limit. A rectifier then forces negative results to zero before the value leaves the stage.

Each input word comes with a valid flag. The result appears, with its own valid flag, exactly one clock later. The accumulator width, output width and shift amount are parameters. A parameter also chooses whether the rectifier is present, so the same block can serve a layer with no activation function.

Top module: `requant_relu`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: When `in_acc[23]` is 0 and `in_acc[22:15]` are all 0, the result is `{1'b0, in_acc[14:8]}`.
- R3: When `in_acc[23]` is 0 and any bit of `in_acc[22:15]` is 1, the result is +127 (8'h7F), with no wrap-around.
- R4: With the rectifier on (the default), any input with `in_acc[23]` equal to 1 gives 8'h00.
- R5: Bits `in_acc[7:0]` have no effect on the result.
- R6: A cycle with `in_valid` low leaves `out_data` unchanged on the following cycle.
- R7: While reset is held, and until the first accepted word, `out_valid` is 0 and `out_data` is 8'h00.
- R8: With the rectifier off, a negative input whose bits 22..15 are all 1 gives `{1'b1, in_acc[14:8]}`, and a negative input with any of those bits at 0 gives -128 (8'h80).
- R9: Every result equals the input divided by 256 and rounded toward minus infinity, then clamped to [-128, 127], then rectified when the rectifier is on.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies `in_acc` |
| in_acc | input | 24 | Signed accumulated sum |
| out_valid | output | 1 | Qualifies `out_data`, one cycle after `in_valid` |
| out_data | output | 8 | Signed requantized, rectified activation |

## Verification
The bench builds the block with its default widths (24-bit input, 8-bit output, shift of 8) twice, once with the rectifier on and once with it off, and drives both with the same stream. Every one of the 65,536 values of bits 23..8 goes through in a back-to-back stream, and the discarded low byte changes from word to word. This covers every guard-bit pattern, every in-range magnitude and both clamp limits, and exposes the negative path that the rectifier would otherwise hide. Idle cycles placed through the stream exercise the valid timing and the holding of the output data.

// File: rtl/requant_pkg.sv
package requant_pkg;

  localparam int unsigned ACC_W_DEF = 24;
  localparam int unsigned OUT_W_DEF = 8;
  localparam int unsigned SHIFT_DEF = 8;

  // How a shifted accumulator value relates to the signed output range.
  typedef enum logic [1:0] {
    CLS_POS_FIT = 2'd0,
    CLS_POS_SAT = 2'd1,
    CLS_NEG_FIT = 2'd2,
    CLS_NEG_SAT = 2'd3
  } fit_cls_e;

endpackage

// File: rtl/rq_rst_sync.sv
module rq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rq_clip.sv
// Classifies the kept field of the accumulator: its sign, and whether the
// guard bits between the sign and the kept magnitude agree with the sign.
module rq_clip
  import requant_pkg::*;
#(
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned OUT_W = OUT_W_DEF,
  parameter int unsigned SHIFT = SHIFT_DEF
) (
  input  logic [ACC_W-SHIFT-1:0] acc_hi,  // accumulator bits ACC_W-1 .. SHIFT
  output logic [OUT_W-2:0]       mag,
  output fit_cls_e               cls
);

  localparam int unsigned HI_W     = ACC_W - SHIFT;
  localparam int unsigned GUARD_LO = OUT_W - 1;
  localparam int unsigned GUARD_HI = HI_W - 2;

  logic                      sign_b;
  logic [GUARD_HI:GUARD_LO]  guard;
  logic                      fits;

  always_comb begin
    sign_b = acc_hi[HI_W-1];
    guard  = acc_hi[GUARD_HI:GUARD_LO];
    mag    = acc_hi[OUT_W-2:0];
    fits   = sign_b ? (&guard) : ~(|guard);
    unique case ({sign_b, fits})
      2'b01:   cls = CLS_POS_FIT;
      2'b00:   cls = CLS_POS_SAT;
      2'b11:   cls = CLS_NEG_FIT;
      default: cls = CLS_NEG_SAT;
    endcase
  end

endmodule

// File: rtl/rq_select.sv
// Forms the output word from the class and kept magnitude; the rectifier is
// chosen at elaboration.
module rq_select
  import requant_pkg::*;
#(
  parameter int unsigned OUT_W      = OUT_W_DEF,
  parameter bit          APPLY_RELU = 1'b1
) (
  input  fit_cls_e         cls,
  input  logic [OUT_W-2:0] mag,
  output logic [OUT_W-1:0] q
);

  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  generate
    if (APPLY_RELU) begin : g_relu
      always_comb begin
        unique case (cls)
          CLS_POS_FIT: q = {1'b0, mag};
          CLS_POS_SAT: q = POS_MAX;
          default:     q = '0;
        endcase
      end
    end else begin : g_linear
      always_comb begin
        unique case (cls)
          CLS_POS_FIT: q = {1'b0, mag};
          CLS_POS_SAT: q = POS_MAX;
          CLS_NEG_FIT: q = {1'b1, mag};
          default:     q = NEG_MIN;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/requant_relu.sv
module requant_relu
  import requant_pkg::*;
#(
  parameter int unsigned ACC_W      = ACC_W_DEF,
  parameter int unsigned OUT_W      = OUT_W_DEF,
  parameter int unsigned SHIFT      = SHIFT_DEF,
  parameter bit          APPLY_RELU = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] in_acc,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  localparam int unsigned HI_W     = ACC_W - SHIFT;
  localparam int unsigned GUARD_LO = SHIFT + OUT_W - 1;

  logic             rst_sync_n;
  logic [OUT_W-2:0] mag;
  fit_cls_e         cls;
  logic [OUT_W-1:0] q_comb;
  logic             unused_low_bits;

  logic             vld_q, vld_d;
  logic [OUT_W-1:0] data_q, data_d;
  logic             data_en;

  assign unused_low_bits = ^in_acc[SHIFT-1:0];

  rq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rq_clip #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_clip (
    .acc_hi (in_acc[ACC_W-1:SHIFT]),
    .mag    (mag),
    .cls    (cls)
  );

  rq_select #(.OUT_W(OUT_W), .APPLY_RELU(APPLY_RELU)) u_sel (
    .cls (cls),
    .mag (mag),
    .q   (q_comb)
  );

  // next state
  always_comb begin
    data_en = in_valid;
    vld_d   = in_valid;
    data_d  = data_en ? q_comb : data_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_data));

  a_r3_pos_saturate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_acc[ACC_W-1] && (|in_acc[ACC_W-2:GUARD_LO]))
    |=> (out_data == {1'b0, {(OUT_W-1){1'b1}}}));

  generate
    if (APPLY_RELU) begin : g_relu_chk
      a_r4_negative_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (in_valid && in_acc[ACC_W-1]) |=> (out_data == '0));
    end else begin : g_lin_chk
      a_r8_negative_floor: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (in_valid && in_acc[ACC_W-1] && !(&in_acc[ACC_W-2:GUARD_LO]))
        |=> (out_data == {1'b1, {(OUT_W-1){1'b0}}}));
    end
  endgenerate

  always_comb begin
    if (HI_W < OUT_W + 1) a_cfg_widths: assert (0);
  end

endmodule

// File: tb/requant_relu_test.sv
`timescale 1ns/1ps
module requant_relu_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_acc;
  logic        ov_relu, ov_raw;
  logic [7:0]  od_relu, od_raw;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // pending expectations for the next sample
  bit         exp_vld;
  logic [7:0] exp_relu, exp_raw;
  string      tag_relu, tag_raw;

  always #5 clk = ~clk;

  requant_relu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
    .out_valid(ov_relu), .out_data(od_relu)
  );

  requant_relu #(.APPLY_RELU(1'b0)) uut_raw (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
    .out_valid(ov_raw), .out_data(od_raw)
  );

  // R9: floor(acc / 256), clamp to [-128,127], optional rectifier
  function automatic int ref_val(logic [23:0] a, bit relu);
    int v;
    v = $signed(a);
    v = v >>> 8;
    if (v > 127)  v = 127;
    if (v < -128) v = -128;
    if (relu && v < 0) v = 0;
    return v;
  endfunction

  function automatic string tag_of(logic [23:0] a, bit relu);
    int v;
    v = $signed(a) >>> 8;
    if (!relu) return "R8";
    if (a[23]) return "R4";
    if (v > 127) return "R3";
    return "R2";
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Samples the previous step's result, then drives a new input.
  task automatic step(bit v, logic [23:0] a);
    int rr, rw;
    @(negedge clk);
    check1("R1", ov_relu, exp_vld);
    check1("R1", ov_raw, exp_vld);
    check8(tag_relu, od_relu, exp_relu);
    check8(tag_raw, od_raw, exp_raw);
    in_valid = v;
    in_acc   = a;
    exp_vld  = v;
    if (v) begin
      rr = ref_val(a, 1'b1);
      rw = ref_val(a, 1'b0);
      exp_relu = rr[7:0];
      exp_raw  = rw[7:0];
      tag_relu = tag_of(a, 1'b1);
      tag_raw  = tag_of(a, 1'b0);
    end else begin
      tag_relu = "R6";
      tag_raw  = "R6";
    end
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_acc   = 24'h0;
    exp_vld  = 1'b0;
    exp_relu = 8'h00;
    exp_raw  = 8'h00;
    tag_relu = "R7";
    tag_raw  = "R7";
    repeat (3) @(negedge clk);
    // R7: reset state while reset is held
    check1("R7", ov_relu, 1'b0);
    check8("R7", od_relu, 8'h00);
    check8("R7", od_raw, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b0, 24'hFFFFFF);          // idle with junk input; next sample is R7 state

    // boundary words
    step(1'b1, 24'h007FFF);          // R2: largest in range -> 7F
    step(1'b1, 24'h008000);          // R3: first overflow -> 7F
    step(1'b1, 24'h7FFFFF);          // R3: full-scale positive
    step(1'b1, 24'hFF8000);          // R8: -128 in range; R4: 00
    step(1'b1, 24'hFF7FFF);          // R8: -129 -> 80
    step(1'b1, 24'h800000);          // R8: most negative -> 80
    step(1'b1, 24'h000100);          // R2: 01
    step(1'b1, 24'hFFFFFF);          // R8: -1 -> FF; R4: 00
    step(1'b0, 24'h123456);          // R6: hold FF / 00
    step(1'b0, 24'h000000);          // R6

    // R5: same upper bits, opposite low bytes
    for (int j = 0; j < 16; j++) begin
      step(1'b1, {16'(j * 4099), 8'h00});
      step(1'b1, {16'(j * 4099), 8'hFF});
    end

    // full sweep of bits 23..8 with a varying discarded low byte (R9)
    for (int k = 0; k < 65536; k++) begin
      step(1'b1, {16'(k), 8'((k * 37 + 11) & 255)});
      if ((k % 4096) == 4095) step(1'b0, 24'hA5A5A5);
    end
    step(1'b0, 24'h0);
    step(1'b0, 24'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule